// File: doc/BRIEF.md
# Gated Frequency Counter with Seven-Segment Readout

This block measures how often a single-bit signal rises in a one-second window and shows the result as a decimal number. A gate is derived from the 50 MHz system clock. It is open for one second and closed for one second. While the gate is open, rising edges of the chosen input are counted. When the gate closes, the count is captured and converted to BCD. It is then encoded onto active-low seven-segment digit outputs, which hold that reading through the next gate period.

The measured input comes from one of two sources, chosen by a select pin. One is an external pin. The other is a built-in test tone, divided from a separate 27 MHz reference. With default parameters the tone is 2000 Hz, so selecting it makes the display read 2000. This gives a self-test without outside equipment. Either source passes through a two-flop synchroniser and a registered edge detector, so all counting is synchronous to the system clock. If more edges arrive than the counter can hold, the counter saturates and the readout shows all nines for that period.

Top module: `freq_counter_top`

## Requirements
- R1: The gate is high for exactly GATE_HALF system clock cycles and then low for GATE_HALF cycles, repeating. The first high phase begins on the first clock edge after reset is released.
- R2: Rising edges of the selected input are counted only while the gate is high. The counter is held at zero while the gate is low, so edges arriving then have no effect on any reading.
- R3: src_sel = 0 measures ext_sig and src_sel = 1 measures the internal tone. Activity on the unselected source has no effect on the reading.
- R4: The internal tone has a period of TONE_PERIOD ref_clk cycles and is high for the first TONE_HIGH of them. With defaults (13500 and 6720 on 27 MHz) it is 2000 Hz, and measuring it reads 2000.
- R5: The count is captured when the gate falls. The display changes at most once per gate period, no later than CNT_W + 3 clock cycles after the fall, and is otherwise stable.
- R6: seg_o bits [7i+6:7i] show decimal digit i, where i = 0 is units and i = 4 is ten-thousands. Segments are active-low, with bit 6 = g down to bit 0 = a. The codes for 0..9 are 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000 and 0011000.
- R7: A count of up to 2^CNT_W - 1 edges is shown exactly, with ovf_o = 0. If more edges arrive in one gate, every digit shows 9 and ovf_o = 1 for that reading.
- R8: After reset every digit shows 0 and ovf_o is 0 until the first reading is produced.
- R9: A source toggling as fast as one level per system clock cycle is counted without missing edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz by default) |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock for the test tone (27 MHz by default) |
| ext_sig | input | 1 | External signal to measure, asynchronous |
| src_sel | input | 1 | Source select: 0 external, 1 internal tone |
| seg_o | output | DIGITS*7 | Active-low segment patterns, digit 0 in the low bits |
| ovf_o | output | 1 | Displayed reading came from a saturated count |

## Verification
The bench builds the block with GATE_HALF = 700, CNT_W = 8, TONE_PERIOD = 7 and TONE_HIGH = 3, with a 20 ns reference clock. A whole gate period then takes 1400 cycles, so eight readings fit in a short run. The narrow counter lets saturation and the exact 255 boundary be reached with edge bursts of a few hundred cycles. The tone gives 20 edges per open gate, which exercises the source select and the window length through the tone path. The chosen counts together cover every digit code from 0 to 9.

// File: rtl/fc_pkg.sv
package fc_pkg;

  localparam int SEG_W = 7;

  // active-low segments, bit 6 = g ... bit 0 = a
  function automatic logic [SEG_W-1:0] seg_of(input logic [3:0] d);
    case (d)
      4'd0:    return 7'b1000000;
      4'd1:    return 7'b1111001;
      4'd2:    return 7'b0100100;
      4'd3:    return 7'b0110000;
      4'd4:    return 7'b0011001;
      4'd5:    return 7'b0010010;
      4'd6:    return 7'b0000010;
      4'd7:    return 7'b1111000;
      4'd8:    return 7'b0000000;
      4'd9:    return 7'b0011000;
      default: return 7'b1111111;
    endcase
  endfunction

endpackage

// File: rtl/fc_gate_gen.sv
module fc_gate_gen #(
  parameter int HALF = 50_000_000
) (
  input  logic clk,
  input  logic rst,
  output logic gate_o
);
  localparam int PERIOD = 2 * HALF;
  localparam int GW     = $clog2(PERIOD);

  logic [GW-1:0] gcnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      gcnt_q <= '0;
      gate_o <= 1'b0;
    end else begin
      gcnt_q <= (gcnt_q == GW'(PERIOD - 1)) ? '0 : gcnt_q + GW'(1);
      gate_o <= (gcnt_q < GW'(HALF));
    end
  end

  // R1
  gate_open_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(gate_o) |-> gcnt_q == GW'(1));
  // R1
  gate_close_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(gate_o) |-> gcnt_q == GW'(HALF + 1));

endmodule

// File: rtl/fc_tone_gen.sv
module fc_tone_gen #(
  parameter int PERIOD = 13_500,
  parameter int HIGH   = 6_720
) (
  input  logic ref_clk,
  input  logic rst,
  output logic tone_o
);
  localparam int TW = $clog2(PERIOD);

  logic [1:0]    rs_q;
  logic          lrst;
  logic [TW-1:0] tcnt_q;

  always_ff @(posedge ref_clk) rs_q <= {rs_q[0], rst};
  assign lrst = rs_q[1];

  always_ff @(posedge ref_clk) begin
    if (lrst) begin
      tcnt_q <= '0;
      tone_o <= 1'b0;
    end else begin
      tcnt_q <= (tcnt_q == TW'(PERIOD - 1)) ? '0 : tcnt_q + TW'(1);
      tone_o <= (tcnt_q < TW'(HIGH));
    end
  end

  // R4
  tone_rise_chk: assert property (@(posedge ref_clk) disable iff (rst || lrst)
    $rose(tone_o) |-> tcnt_q == TW'(1));

endmodule

// File: rtl/fc_edge_counter.sv
module fc_edge_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_i,
  input  logic             gate_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [2:0] sh_q;
  logic       rise;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[1:0], sig_i};
  end
  assign rise = sh_q[1] & ~sh_q[2];

  always_ff @(posedge clk) begin
    if (rst || !gate_i) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (rise) begin
      if (cnt_o == CMAX) ovf_o <= 1'b1;
      else               cnt_o <= cnt_o + CNT_W'(1);
    end
  end

  // R2
  held_clear_chk: assert property (@(posedge clk) disable iff (rst)
    !gate_i |=> (cnt_o == '0 && !ovf_o));
  // R7
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_i && cnt_o == CMAX) |=> cnt_o == CMAX);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_i && !rise) |=> $stable(cnt_o));

endmodule

// File: rtl/fc_bin2bcd.sv
module fc_bin2bcd #(
  parameter int BIN_W  = 16,
  parameter int DIGITS = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [BIN_W-1:0]    bin_i,
  output logic [DIGITS*4-1:0] bcd_o,
  output logic                done_o
);
  localparam int BW = DIGITS * 4;
  localparam int IW = $clog2(BIN_W + 1);

  logic [BW-1:0]       acc_q;
  logic [BW-1:0]       adj;
  logic [BIN_W-1:0]    bin_q;
  logic [IW-1:0]       itr_q;
  logic                busy_q;
  logic [BW+BIN_W-1:0] nxt;

  for (genvar i = 0; i < DIGITS; i++) begin : g_adj
    assign adj[4*i +: 4] = (acc_q[4*i +: 4] >= 4'd5) ? acc_q[4*i +: 4] + 4'd3
                                                       : acc_q[4*i +: 4];
  end
  assign nxt = {adj, bin_q} << 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      bin_q  <= '0;
      itr_q  <= '0;
      busy_q <= 1'b0;
      done_o <= 1'b0;
      bcd_o  <= '0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        acc_q  <= '0;
        bin_q  <= bin_i;
        itr_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q) begin
        acc_q <= nxt[BW+BIN_W-1:BIN_W];
        bin_q <= nxt[BIN_W-1:0];
        itr_q <= itr_q + IW'(1);
        if (itr_q == IW'(BIN_W - 1)) begin
          busy_q <= 1'b0;
          done_o <= 1'b1;
          bcd_o  <= nxt[BW+BIN_W-1:BIN_W];
        end
      end
    end
  end

  for (genvar i = 0; i < DIGITS; i++) begin : g_chk
    // R6
    digit_range_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> bcd_o[4*i +: 4] <= 4'd9);
  end

endmodule

// File: rtl/freq_counter_top.sv
module freq_counter_top #(
  parameter int GATE_HALF   = 50_000_000,
  parameter int TONE_PERIOD = 13_500,
  parameter int TONE_HIGH   = 6_720,
  parameter int CNT_W       = 16,
  parameter int DIGITS      = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_clk,
  input  logic                ext_sig,
  input  logic                src_sel,
  output logic [DIGITS*7-1:0] seg_o,
  output logic                ovf_o
);
  import fc_pkg::*;

  logic             gate, gate_prev_q, gate_fall;
  logic             tone, meas;
  logic [CNT_W-1:0] cnt;
  logic             cnt_ovf;
  logic [CNT_W-1:0] latch_q;
  logic             lovf_q, start_q;
  logic [DIGITS*4-1:0] bcd;
  logic             bcd_done;

  fc_gate_gen #(.HALF(GATE_HALF)) u_gate (
    .clk(clk), .rst(rst), .gate_o(gate));

  fc_tone_gen #(.PERIOD(TONE_PERIOD), .HIGH(TONE_HIGH)) u_tone (
    .ref_clk(ref_clk), .rst(rst), .tone_o(tone));

  assign meas = src_sel ? tone : ext_sig;

  fc_edge_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .sig_i(meas), .gate_i(gate),
    .cnt_o(cnt), .ovf_o(cnt_ovf));

  assign gate_fall = gate_prev_q & ~gate;

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_prev_q <= 1'b0;
      latch_q     <= '0;
      lovf_q      <= 1'b0;
      start_q     <= 1'b0;
    end else begin
      gate_prev_q <= gate;
      start_q     <= gate_fall;
      if (gate_fall) begin
        latch_q <= cnt;
        lovf_q  <= cnt_ovf;
      end
    end
  end

  fc_bin2bcd #(.BIN_W(CNT_W), .DIGITS(DIGITS)) u_bcd (
    .clk(clk), .rst(rst), .start_i(start_q), .bin_i(latch_q),
    .bcd_o(bcd), .done_o(bcd_done));

  for (genvar i = 0; i < DIGITS; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (rst)           seg_o[7*i +: 7] <= seg_of(4'd0);
      else if (bcd_done) seg_o[7*i +: 7] <= seg_of(lovf_q ? 4'd9 : bcd[4*i +: 4]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           ovf_o <= 1'b0;
    else if (bcd_done) ovf_o <= lovf_q;
  end

  // R5
  disp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bcd_done |=> ($stable(seg_o) && $stable(ovf_o)));
  // R7
  ovf_nines_chk: assert property (@(posedge clk) disable iff (rst)
    (bcd_done && lovf_q) |=> (seg_o == {DIGITS{seg_of(4'd9)}} && ovf_o));

endmodule

// File: tb/sim_freq_counter_top.sv
`timescale 1ns/1ps
module sim_freq_counter_top;
  localparam int GH   = 700;
  localparam int CW   = 8;
  localparam int ND   = 5;
  localparam int GP   = 2 * GH;
  localparam int BMAX = (1 << CW) - 1;
  localparam int NP   = 8;
  localparam int LAT  = 40;

  logic clk = 1'b0, ref_clk = 1'b0, rst = 1'b1;
  logic ext_sig = 1'b0, src_sel = 1'b0;
  logic [ND*7-1:0] seg_o;
  logic ovf_o;

  always #2  clk = ~clk;
  always #10 ref_clk = ~ref_clk;

  freq_counter_top #(.GATE_HALF(GH), .TONE_PERIOD(7), .TONE_HIGH(3),
                     .CNT_W(CW), .DIGITS(ND)) u0 (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .ext_sig(ext_sig),
    .src_sel(src_sel), .seg_o(seg_o), .ovf_o(ovf_o));

  // per-period plan: selected source, external edges, level width in cycles
  int    sel_p [NP] = '{0, 0, 0, 0, 1, 1, 0, 0};
  int    n_ed  [NP] = '{37, 123, 255, 300, 50, 0, 164, 89};
  int    hw_ed [NP] = '{2, 2, 1, 1, 2, 2, 2, 1};
  string tag_p [NP] = '{"R2/R6", "R2", "R7/R9", "R7", "R3/R4", "R1/R4", "R6", "R5/R9"};

  int  cyc = 0;
  int  n_chk = 0, n_fail = 0;
  bit  done_run = 0;

  always @(posedge clk) if (!rst) cyc <= cyc + 1;

  function automatic int seg2dig(input logic [6:0] s);
    case (s)
      7'b1000000: return 0;  7'b1111001: return 1;
      7'b0100100: return 2;  7'b0110000: return 3;
      7'b0011001: return 4;  7'b0010010: return 5;
      7'b0000010: return 6;  7'b1111000: return 7;
      7'b0000000: return 8;  7'b0011000: return 9;
      default:    return -1;
    endcase
  endfunction

  function automatic int disp_val(input logic [ND*7-1:0] s);
    int v = 0;
    for (int i = ND - 1; i >= 0; i--) begin
      int d = seg2dig(s[7*i +: 7]);
      if (d < 0) return -1;
      v = v * 10 + d;
    end
    return v;
  endfunction

  // expected reading for period p (p < 0 means the reset reading)
  task automatic exp_of(input int p, output int lo, output int hi, output bit ov);
    if (p < 0) begin lo = 0; hi = 0; ov = 0; end
    else if (sel_p[p] == 1) begin lo = 19; hi = 21; ov = 0; end
    else if (n_ed[p] > BMAX) begin lo = 99999; hi = 99999; ov = 1; end
    else begin lo = n_ed[p]; hi = n_ed[p]; ov = 0; end
  endtask

  // reference comparison on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done_run && cyc >= 1) begin
      int p = -1;
      int v, lo, hi, plo, phi;
      bit ov, pov, ok_now, ok_prev;
      string tg;
      for (int i = 0; i < NP; i++) if (cyc >= i * GP + GH + 2) p = i;
      v = disp_val(seg_o);
      exp_of(p, lo, hi, ov);
      ok_now = (v >= lo && v <= hi && ovf_o == ov);
      tg = (p < 0) ? "R8" : tag_p[p];
      n_chk++;
      if (p >= 0 && cyc < p * GP + GH + 2 + LAT) begin
        exp_of(p - 1, plo, phi, pov);
        ok_prev = (v >= plo && v <= phi && ovf_o == pov);
        if (!(ok_now || ok_prev)) begin
          n_fail++;
          $display("FAIL R5 cyc %0d: display %0d ovf %0d, expected %0d..%0d or %0d..%0d",
                   cyc, v, ovf_o, lo, hi, plo, phi);
        end
      end else if (!ok_now) begin
        n_fail++;
        $display("FAIL %s cyc %0d: display %0d ovf %0d, expected %0d..%0d ovf %0d",
                 tg, cyc, v, ovf_o, lo, hi, ov);
      end
    end
  end

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic burst(input int n, input int hw);
    for (int k = 0; k < n; k++) begin
      ext_sig = 1'b1;
      repeat (hw) @(negedge clk);
      ext_sig = 1'b0;
      repeat (hw) @(negedge clk);
    end
  endtask

  task automatic finish_run;
    if (!done_run) begin
      done_run = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20) @(negedge clk);
    // R8: reading straight after reset
    n_chk++;
    if (disp_val(seg_o) != 0 || ovf_o !== 1'b0) begin
      n_fail++;
      $display("FAIL R8: display %0d ovf %0d, expected 0 ovf 0", disp_val(seg_o), ovf_o);
    end
    rst = 1'b0;
    for (int p = 0; p < NP; p++) begin
      if (p > 0) begin
        wait_to(p * GP - 50);
        src_sel = sel_p[p][0];
      end
      wait_to(p * GP + 20);
      burst(n_ed[p], hw_ed[p]);
      if (p == 0) begin
        // R2: edges while the gate is closed must not reach the next reading
        wait_to(GH + 20);
        burst(10, 2);
      end
    end
    wait_to((NP - 1) * GP + GH + 2 + LAT + 20);
    finish_run();
  end

  initial begin
    #400000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: cycle %0d, expected end near %0d", cyc, NP * GP);
    finish_run();
  end

endmodule